// File: doc/BRIEF.md
# Fractional Multiply-Accumulate with Convergent Rounding

This block is the arithmetic core of a 24-bit fixed-point DSP data path. It takes an accumulator value and one multiply term, adds or subtracts the term, and rounds the sum convergently. It returns the updated accumulator one clock after a start strobe. The multiply term is one of two things. In the first form it is the fractional product of two signed 24-bit operands. In the second form it is one signed operand scaled by 2^-n, where n is an immediate count. The accumulator is 56 bits wide: an 8-bit extension (bits 55:48), a 24-bit high word (bits 47:24) and a 24-bit low word (bits 23:0).

Rounding adds a constant just below a kept least significant bit, and the carry reaches the high word. A 2-bit scale code chooses where the kept bit lies. When the discarded bits equal exactly one half, the kept bit is forced to zero, which rounds to even. After rounding, the discarded bits and the whole low word read as zero, so the result can feed straight back as the next accumulator input. An overflow flag marks results whose extension holds significant bits.

Top module: `macr_unit`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `acc_out`, `done` and `ovf` are all zero.
- R2: `done` is high in exactly the cycle after a cycle with `start` high. `acc_out` and `ovf` take their new values in that same cycle. When `start` is low, `acc_out` and `ovf` hold their values, whatever the other inputs do.
- R3: With `use_imm`=0, the term is the signed product `op_a*op_b`, shifted left one bit and sign-extended to 56 bits. With `negate`=0 the sum is `acc_in + term`, taken modulo 2^56. With `scale`=00 the sum is rounded by adding 2^23 and clearing bits 23:0.
- R4: With `negate`=1 the term is subtracted from `acc_in` instead of added.
- R5: In scale 00, when bits 23:0 of the sum equal 0x800000 exactly, bit 24 of the result is forced to 0. For example, 0x00_000001_800000 rounds to 0x00_000002_000000, and so does 0x00_000002_800000.
- R6: Scale 01 (scale down) adds 2^24 and clears bits 24:0. When bits 24:0 of the sum equal 2^24 exactly, bit 25 is forced to 0.
- R7: Scale 10 (scale up) adds 2^22 and clears bits 23:0. When bits 22:0 equal 2^22 exactly, bit 23 is forced to 0, which that clearing leaves at zero in any case.
- R8: Scale 11 gives the same result as scale 00.
- R9: With `use_imm`=1, the term is `op_a` placed in bits 47:24, sign-extended to 56 bits and shifted right arithmetically by `shamt`. A `shamt` above 23 acts as 23, and `op_b` has no effect.
- R10: `ovf` is 1 exactly when bits 55:47 of the new `acc_out` are not all equal.
- R11: For `acc_in`=0x00_100000_000000 and `op_a`=`op_b`=0x123456, with add, scale 00 and product form, `acc_out` is 0x00_1296CE_000000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Perform one operation on this cycle's inputs |
| op_a | input | 24 | Signed fractional operand A |
| op_b | input | 24 | Signed fractional operand B (product form only) |
| shamt | input | 5 | Immediate right-shift count n for the 2^-n form |
| use_imm | input | 1 | 1 selects the op_a*2^-n form |
| negate | input | 1 | 1 subtracts the term |
| scale | input | 2 | Rounding position: 00 none, 01 down, 10 up, 11 as 00 |
| acc_in | input | 56 | Accumulator operand |
| acc_out | output | 56 | Rounded accumulator result |
| done | output | 1 | Result valid strobe |
| ovf | output | 1 | Extension holds significant bits |

## Verification
The hardest case to reach is the exact-half tie. Random operands almost never leave the discarded bits at exactly half, so they do not exercise the round-to-even correction. The stimulus reaches it directly with zero operands, which make the term zero, and places the tie pattern in `acc_in` for each scale code. It uses both odd and even kept bits, so a design that always rounds up or always rounds down gives a wrong result. The most negative operand squared produces the one product that sets the overflow flag with a zero extension. Shift counts of 0, 23 and above 23 cover the clamp.

// File: rtl/macr_pkg.sv
package macr_pkg;

  typedef enum logic [1:0] {
    SCL_NONE = 2'b00,
    SCL_DOWN = 2'b01,
    SCL_UP   = 2'b10,
    SCL_RSVD = 2'b11
  } scale_e;

  // Position of the rounding constant bit for a scale code.
  function automatic int rnd_pos(input int code, input int dw);
    case (code)
      1:       return dw;
      2:       return dw - 2;
      default: return dw - 1;
    endcase
  endfunction

endpackage

// File: rtl/macr_term.sv
module macr_term #(
  parameter int DW  = 24,
  parameter int EW  = 8,
  parameter int SHW = 5,
  localparam int ACC_W = EW + 2 * DW
) (
  input  logic [DW-1:0]    op_a,
  input  logic [DW-1:0]    op_b,
  input  logic [SHW-1:0]   shamt,
  input  logic             use_imm,
  input  logic             negate,
  output logic [ACC_W-1:0] term
);

  localparam int MAXSH = DW - 1;

  logic signed [2*DW-1:0]  prod_raw;
  logic signed [ACC_W-1:0] prod_ext;
  logic signed [ACC_W-1:0] imm_base;
  logic signed [ACC_W-1:0] imm_shf;
  logic [SHW-1:0]          n_eff;
  logic [ACC_W-1:0]        pick;

  always_comb begin
    prod_raw = $signed(op_a) * $signed(op_b);
    prod_ext = ACC_W'(prod_raw) <<< 1;
  end

  always_comb begin
    imm_base = {{EW{op_a[DW-1]}}, op_a, {DW{1'b0}}};
    n_eff    = (int'(shamt) > MAXSH) ? SHW'(MAXSH) : shamt;
    imm_shf  = imm_base >>> n_eff;
  end

  always_comb begin
    pick = use_imm ? imm_shf : prod_ext;
    term = negate ? (~pick + ACC_W'(1)) : pick;
  end

endmodule

// File: rtl/macr_round.sv
module macr_round #(
  parameter int DW = 24,
  parameter int EW = 8,
  localparam int ACC_W = EW + 2 * DW
) (
  input  logic [ACC_W-1:0] sum,
  input  logic [1:0]       scale,
  output logic [ACC_W-1:0] res
);

  logic [ACC_W-1:0] cand [4];

  for (genvar g = 0; g < 4; g++) begin : g_mode
    localparam int K = macr_pkg::rnd_pos(g, DW);
    localparam logic [ACC_W-1:0] HALF  = ACC_W'(1) << K;
    localparam logic [ACC_W-1:0] BELOW = (ACC_W'(1) << (K + 1)) - ACC_W'(1);
    localparam logic [ACC_W-1:0] LOWW  = (ACC_W'(1) << DW) - ACC_W'(1);
    localparam logic [ACC_W-1:0] KEEP  = ACC_W'(1) << (K + 1);

    logic [ACC_W-1:0] added;
    logic             tie;

    always_comb begin
      added = sum + HALF;
      tie   = ((sum & BELOW) == HALF);
      cand[g] = added & ~BELOW & ~LOWW;
      if (tie) cand[g] = cand[g] & ~KEEP;
    end
  end

  always_comb begin
    unique case (macr_pkg::scale_e'(scale))
      macr_pkg::SCL_DOWN: res = cand[1];
      macr_pkg::SCL_UP:   res = cand[2];
      macr_pkg::SCL_RSVD: res = cand[3];
      default:            res = cand[0];
    endcase
  end

endmodule

// File: rtl/macr_unit.sv
module macr_unit #(
  parameter int DW  = 24,
  parameter int EW  = 8,
  parameter int SHW = 5,
  localparam int ACC_W = EW + 2 * DW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [DW-1:0]    op_a,
  input  logic [DW-1:0]    op_b,
  input  logic [SHW-1:0]   shamt,
  input  logic             use_imm,
  input  logic             negate,
  input  logic [1:0]       scale,
  input  logic [ACC_W-1:0] acc_in,
  output logic [ACC_W-1:0] acc_out,
  output logic             done,
  output logic             ovf
);

  localparam int TOPB = 2 * DW - 1;

  logic [ACC_W-1:0] term;
  logic [ACC_W-1:0] sum;
  logic [ACC_W-1:0] rnd;
  logic             ovf_c;

  macr_term #(.DW(DW), .EW(EW), .SHW(SHW)) u_term (
    .op_a    (op_a),
    .op_b    (op_b),
    .shamt   (shamt),
    .use_imm (use_imm),
    .negate  (negate),
    .term    (term)
  );

  assign sum = acc_in + term;

  macr_round #(.DW(DW), .EW(EW)) u_round (
    .sum   (sum),
    .scale (scale),
    .res   (rnd)
  );

  always_comb begin
    ovf_c = !((&rnd[ACC_W-1:TOPB]) || !(|rnd[ACC_W-1:TOPB]));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_out <= '0;
      done    <= 1'b0;
      ovf     <= 1'b0;
    end else begin
      done <= start;
      if (start) begin
        acc_out <= rnd;
        ovf     <= ovf_c;
      end
    end
  end

endmodule

// File: rtl/macr_unit_chk.sv
module macr_unit_chk #(
  parameter int DW = 24,
  parameter int EW = 8,
  localparam int ACC_W = EW + 2 * DW
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic [1:0]       scale,
  input logic [ACC_W-1:0] acc_out,
  input logic             done,
  input logic             ovf
);

  // R2
  a_r2_done_follows: assert property (@(posedge clk) disable iff (rst)
    start |=> done);
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !start |=> !done);
  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    !start |=> ($stable(acc_out) && $stable(ovf)));
  // R3
  a_r3_low_clear: assert property (@(posedge clk) disable iff (rst)
    acc_out[DW-1:0] == '0);
  // R6
  a_r6_scale_down_bit: assert property (@(posedge clk) disable iff (rst)
    (start && scale == 2'b01) |=> (acc_out[DW] == 1'b0));
  // R10
  a_r10_ovf_match: assert property (@(posedge clk) disable iff (rst)
    done |-> (ovf == ($countones(acc_out[ACC_W-1:2*DW-1]) != 0 &&
                      $countones(acc_out[ACC_W-1:2*DW-1]) != EW + 1)));

endmodule

bind macr_unit macr_unit_chk #(.DW(DW), .EW(EW)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .start   (start),
  .scale   (scale),
  .acc_out (acc_out),
  .done    (done),
  .ovf     (ovf)
);

// File: tb/macr_unit_bench.sv
`timescale 1ns/1ps
module macr_unit_bench;

  logic        clk = 1'b0;
  logic        rst;
  logic        start;
  logic [23:0] op_a, op_b;
  logic [4:0]  shamt;
  logic        use_imm, negate;
  logic [1:0]  scale;
  logic [55:0] acc_in;
  logic [55:0] acc_out;
  logic        done, ovf;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  macr_unit u_macr_unit (
    .clk(clk), .rst(rst), .start(start), .op_a(op_a), .op_b(op_b),
    .shamt(shamt), .use_imm(use_imm), .negate(negate), .scale(scale),
    .acc_in(acc_in), .acc_out(acc_out), .done(done), .ovf(ovf)
  );

  // Reference model: returns {ovf, result}
  function automatic logic [56:0] ref_op(
    input logic [55:0] acc, input logic [23:0] a, input logic [23:0] b,
    input int n, input bit imm, input bit neg, input logic [1:0] sc);
    longint t, s;
    logic [63:0] u, mask, half;
    int k, nn;
    bit x;
    if (imm) begin
      nn = (n > 23) ? 23 : n;
      t = (longint'($signed(a)) * (longint'(1) << 24)) >>> nn;
    end else begin
      t = longint'($signed(a)) * longint'($signed(b)) * 2;
    end
    s = longint'($signed({{8{acc[55]}}, acc}));
    s = neg ? s - t : s + t;
    k = (sc == 2'b01) ? 24 : (sc == 2'b10) ? 22 : 23;
    half = 64'd1 << k;
    mask = (64'd1 << (k + 1)) - 64'd1;
    u = 64'(s);
    x = ((u & mask) == half);
    u = (u + half) & ~mask & ~64'hFFFFFF;
    if (x) u = u & ~(64'd1 << (k + 1));
    u = u & 64'h00FF_FFFF_FFFF_FFFF;
    return {(u[55:47] != 9'h000 && u[55:47] != 9'h1FF), u[55:0]};
  endfunction

  task automatic chk(input string req, input logic [56:0] act,
                     input logic [56:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run(input string req, input logic [55:0] acc,
                     input logic [23:0] a, input logic [23:0] b, input int n,
                     input bit imm, input bit neg, input logic [1:0] sc);
    logic [56:0] exp;
    exp = ref_op(acc, a, b, n, imm, neg, sc);
    @(negedge clk);
    acc_in = acc; op_a = a; op_b = b; shamt = 5'(n);
    use_imm = imm; negate = neg; scale = sc; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk({req, " done"}, {56'd0, done}, 57'd1);
    chk(req, {ovf, acc_out}, exp);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin : main
    logic [56:0] held;
    void'($urandom(32'd4711));
    rst = 1'b1; start = 1'b0; op_a = '0; op_b = '0; shamt = '0;
    use_imm = 1'b0; negate = 1'b0; scale = 2'b00; acc_in = '0;
    repeat (3) @(negedge clk);
    // R1
    chk("R1 reset", {ovf, acc_out}, 57'd0);
    chk("R1 reset done", {56'd0, done}, 57'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after reset", {done, ovf, acc_out[54:0]}, 57'd0);

    // R11 example
    run("R11", 56'h00_100000_000000, 24'h123456, 24'h123456, 0, 0, 0, 2'b00);
    chk("R11 const", {1'b0, acc_out}, {1'b0, 56'h00_1296CE_000000});

    // R2 hold: inputs change without start
    held = {ovf, acc_out};
    @(negedge clk);
    acc_in = 56'hFF_FFFFFF_FFFFFF; op_a = 24'h7FFFFF; scale = 2'b01;
    chk("R2 no done", {56'd0, done}, 57'd0);
    @(negedge clk);
    chk("R2 hold", {ovf, acc_out}, held);
    chk("R2 no done 2", {56'd0, done}, 57'd0);

    // R3 / R4
    run("R3", 56'h00_000000_000000, 24'h400000, 24'h400000, 0, 0, 0, 2'b00);
    run("R4", 56'h00_100000_000000, 24'h400000, 24'h200000, 0, 0, 1, 2'b00);
    run("R4 neg", 56'h00_000000_000000, 24'hC00000, 24'h400000, 0, 0, 1, 2'b00);
    // R5 ties
    run("R5 odd tie", 56'h00_000001_800000, 24'h0, 24'h0, 0, 0, 0, 2'b00);
    chk("R5 odd const", {1'b0, acc_out}, {1'b0, 56'h00_000002_000000});
    run("R5 even tie", 56'h00_000002_800000, 24'h0, 24'h0, 0, 0, 0, 2'b00);
    chk("R5 even const", {1'b0, acc_out}, {1'b0, 56'h00_000002_000000});
    run("R5 over half", 56'h00_000002_800001, 24'h0, 24'h0, 0, 0, 0, 2'b00);
    // R6
    run("R6 tie odd", 56'h00_000003_000000, 24'h0, 24'h0, 0, 0, 0, 2'b01);
    run("R6 tie even", 56'h00_000001_000000, 24'h0, 24'h0, 0, 0, 0, 2'b01);
    run("R6 plain", 56'h00_123457_654321, 24'h0, 24'h0, 0, 0, 0, 2'b01);
    // R7
    run("R7 tie", 56'h00_000001_C00000, 24'h0, 24'h0, 0, 0, 0, 2'b10);
    run("R7 carry", 56'h00_000001_E00000, 24'h0, 24'h0, 0, 0, 0, 2'b10);
    run("R7 tie even", 56'h00_000001_400000, 24'h0, 24'h0, 0, 0, 0, 2'b10);
    // R8
    run("R8 tie", 56'h00_000001_800000, 24'h0, 24'h0, 0, 0, 0, 2'b11);
    run("R8 prod", 56'h00_100000_000000, 24'h123456, 24'h123456, 0, 0, 0, 2'b11);
    chk("R8 const", {1'b0, acc_out}, {1'b0, 56'h00_1296CE_000000});
    // R9
    run("R9 n0", 56'h00_000000_000000, 24'h812345, 24'h555555, 0, 1, 0, 2'b00);
    run("R9 n23", 56'h00_000000_000000, 24'h7FFFFF, 24'h0, 23, 1, 0, 2'b00);
    run("R9 n31", 56'h00_000000_000000, 24'h7FFFFF, 24'h0, 31, 1, 0, 2'b00);
    run("R9 n31b", 56'h00_000000_000000, 24'h7FFFFF, 24'hABCDEF, 31, 1, 0, 2'b00);
    chk("R9 clamp", {1'b0, acc_out}, {1'b0, 56'h00_000001_000000});
    run("R9 neg", 56'h00_200000_000000, 24'h900000, 24'h0, 5, 1, 1, 2'b01);
    // R10
    run("R10 minsq", 56'h00_000000_000000, 24'h800000, 24'h800000, 0, 0, 0, 2'b00);
    chk("R10 flag", {56'd0, ovf}, 57'd1);
    run("R10 neg", 56'hFF_000000_000000, 24'h0, 24'h0, 0, 0, 0, 2'b00);
    run("R10 clear", 56'h00_000010_000000, 24'h0, 24'h0, 0, 0, 0, 2'b00);
    chk("R10 flag0", {56'd0, ovf}, 57'd0);

    // Random mix
    for (int i = 0; i < 400; i++) begin
      logic [55:0] ra;
      ra = {$urandom(), $urandom()} >> 8;
      if ($urandom_range(1, 0) == 0) ra[55:44] = {12{ra[43]}};
      run("R3 R4 R6 R7 R9 rand", ra, 24'($urandom()), 24'($urandom()),
          int'($urandom_range(31, 0)), 1'($urandom()), 1'($urandom()),
          2'($urandom()));
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule